// File: doc/BRIEF.md
# Self-Running Program Counter Sequencer

This block walks a wide-instruction compute cluster through its instruction memory with no help from the system bus. A bus wrapper writes a nonzero final instruction index into a dedicated end register. That write starts a run: the program counter clears to zero and then advances by one every clock. The counter drives the instruction-memory read address directly.

On every cycle the counter is compared with the stored end index. When they are equal the run stops and a one-cycle completion pulse goes to the wrapper, which can then accept bus traffic again. While a run is active, the wrapper sees `busy` and turns bus accesses away.

To recover from a stuck program, the wrapper can send a kill command at any time. A kill erases the stored end index and stops the run on the next edge, without a completion pulse. There is no branching. Instructions are fetched strictly in order from index 0 to the end index minus one.

Top module: `pc_sequencer`

## Requirements
- R1: After reset `busy`, `done` and `fetch_vld` are 0 and `imem_addr` is 0.
- R2: While idle, a cycle with `wr_en`=1, `wr_kill`=0 and nonzero `wr_data` stores `wr_data` as the end index. In the next cycle `busy`=1 and `imem_addr`=0.
- R3: While running and not at the end index, `imem_addr` rises by exactly 1 every clock.
- R4: `fetch_vld` is 1 exactly while `busy`=1 and `imem_addr` differs from the end index, so a run with end index E issues the fetch addresses 0..E-1, each once and in order.
- R5: In the cycle after `imem_addr` equals the end index, `busy` is 0 and `done` is 1 for exactly one cycle. `busy` is high for E+1 cycles in total.
- R6: After a run ends, `imem_addr` holds its last value until the next start.
- R7: A write with `wr_kill`=0 and `wr_data`=0 does not start a run.
- R8: A cycle with `wr_en`=1 and `wr_kill`=1 (any data) clears the end index. In the next cycle `busy`=0 and `done`=0, and `imem_addr` holds. A kill takes priority over a completion in the same cycle.
- R9: Start writes that arrive while a run is active are ignored, and the run's fetch sequence and length are unchanged.
- R10: An end index of 0x5E gives exactly 94 fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Command strobe from the bus wrapper |
| wr_kill | input | 1 | With `wr_en`: erase the end index and stop |
| wr_data | input | PC_W | End index to load |
| imem_addr | output | PC_W | Instruction-memory read address (program counter) |
| fetch_vld | output | 1 | Current address is an instruction to execute |
| busy | output | 1 | Run in progress; wrapper must refuse bus accesses |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same edge: the counter reaching the end index and a kill command. The bench sends a kill in exactly the cycle where `imem_addr` equals the end index. It then expects `busy` to drop with no `done` pulse and no extra fetch, and the scoreboard flags any completion token it was not told to expect. A second collision puts a start write in the middle of a run. That run must still produce its original address sequence and length.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_NULL = 2'd2,
    CMD_KILL = 2'd3
  } pcs_cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } pcs_state_e;
endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/pcs_cmd_decode.sv
module pcs_cmd_decode
  import pcs_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            wr_en,
  input  logic            wr_kill,
  input  logic [PC_W-1:0] wr_data,
  output pcs_cmd_e        cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (wr_en) begin
      if (wr_kill)       cmd = CMD_KILL;
      else if (|wr_data) cmd = CMD_LOAD;
      else               cmd = CMD_NULL;
    end
  end
endmodule

// File: rtl/pcs_end_reg.sv
module pcs_end_reg #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            clear,
  input  logic [PC_W-1:0] din,
  output logic [PC_W-1:0] q
);
  logic [PC_W-1:0] end_d;
  logic            end_en;

  always_comb begin
    end_en = load | clear;
    end_d  = clear ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (end_en) q <= end_d;
  end

  AST_END_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (q == '0)); // R8
endmodule

// File: rtl/pcs_counter.sv
module pcs_counter #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  output logic [PC_W-1:0] q
);
  logic [PC_W-1:0] pc_d;
  logic            pc_en;

  always_comb begin
    pc_en = clr | inc;
    pc_d  = clr ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (pc_en) q <= pc_d;
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (q == $past(q) + 1'b1)); // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(q)); // R6
  AST_PC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)); // R2
endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pcs_cmd_e cmd,
  input  logic     match,
  output logic     busy,
  output logic     done,
  output logic     start_acc,
  output logic     abort,
  output logic     inc
);
  pcs_state_e state_q, state_d;
  logic       done_d;

  always_comb begin
    state_d   = state_q;
    start_acc = 1'b0;
    abort     = (cmd == CMD_KILL);
    inc       = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd == CMD_LOAD) begin
          start_acc = 1'b1;
          state_d   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (match) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          inc = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  assign busy = (state_q == ST_RUN);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_MATCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && match && cmd != CMD_KILL) |=> (!busy && done)); // R5
  AST_KILL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_KILL) |=> (!busy && !done)); // R8
  AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !match && cmd == CMD_LOAD) |=> busy); // R9
  AST_NULL_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == CMD_NULL) |=> !busy); // R7
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W       = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_kill,
  input  logic [PC_W-1:0] wr_data,
  output logic [PC_W-1:0] imem_addr,
  output logic            fetch_vld,
  output logic            busy,
  output logic            done
);
  logic            rst_ns;
  pcs_cmd_e        cmd;
  logic [PC_W-1:0] end_q;
  logic [PC_W-1:0] pc_q;
  logic            match;
  logic            start_acc;
  logic            abort;
  logic            inc;

  pcs_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  pcs_cmd_decode #(.PC_W(PC_W)) u_dec (
    .wr_en   (wr_en),
    .wr_kill (wr_kill),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  pcs_end_reg #(.PC_W(PC_W)) u_end (
    .clk   (clk),
    .rst_n (rst_ns),
    .load  (start_acc),
    .clear (abort),
    .din   (wr_data),
    .q     (end_q)
  );

  pcs_counter #(.PC_W(PC_W)) u_pc (
    .clk   (clk),
    .rst_n (rst_ns),
    .clr   (start_acc),
    .inc   (inc),
    .q     (pc_q)
  );

  always_comb begin
    match = (pc_q == end_q);
  end

  pcs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ns),
    .cmd       (cmd),
    .match     (match),
    .busy      (busy),
    .done      (done),
    .start_acc (start_acc),
    .abort     (abort),
    .inc       (inc)
  );

  assign imem_addr = pc_q;
  assign fetch_vld = busy & ~match;

  AST_RUN_HAS_END: assert property (@(posedge clk) disable iff (!rst_ns)
    busy |-> (end_q != '0)); // R2
  AST_START_ADDR0: assert property (@(posedge clk) disable iff (!rst_ns)
    (!busy && cmd == CMD_LOAD) |=> (busy && imem_addr == '0)); // R2
endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  localparam int PC_W   = 8;
  localparam int CLK_PS = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic            wr_kill = 1'b0;
  logic [PC_W-1:0] wr_data = '0;
  logic [PC_W-1:0] imem_addr;
  logic            fetch_vld;
  logic            busy;
  logic            done;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  // scoreboard item: is_done=1 means a completion token
  typedef struct { bit is_done; int addr; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PS/2) clk = ~clk;

  pc_sequencer #(.PC_W(PC_W)) i_pc_sequencer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kill(wr_kill),
    .wr_data(wr_data), .imem_addr(imem_addr), .fetch_vld(fetch_vld),
    .busy(busy), .done(done)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pops expected fetches and completion tokens (R3 R4 R5 R8)
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (fetch_vld) begin
        if (exp_q.size() == 0 || exp_q[0].is_done) chk("R4 unexpected fetch", int'(imem_addr), -1);
        else begin
          chk("R3/R4 fetch addr", int'(imem_addr), exp_q[0].addr);
          void'(exp_q.pop_front());
        end
      end
      if (done) begin
        if (exp_q.size() == 0 || !exp_q[0].is_done) chk("R5/R8 unexpected done", 1, 0);
        else begin
          chk("R5 done token", 1, 1);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  // driver: one run with end index endv; kill_at/poke_at are counter values (-1 = none)
  task automatic run_prog(int endv, int kill_at, int poke_at, string req);
    int cyc = 0;
    int bcnt = 0;
    int last;
    exp_t it;
    last = (kill_at < 0) ? endv - 1 : ((kill_at >= endv) ? endv - 1 : kill_at);
    for (int a = 0; a <= last; a++) begin
      it.is_done = 1'b0; it.addr = a; exp_q.push_back(it);
    end
    if (kill_at < 0) begin
      it.is_done = 1'b1; it.addr = 0; exp_q.push_back(it);
    end
    wr_en = 1'b1; wr_kill = 1'b0; wr_data = PC_W'(endv);
    @(negedge clk);
    chk({req, " R2 start busy"}, int'(busy), 1);
    chk({req, " R2 start addr"}, int'(imem_addr), 0);
    while (busy && bcnt < 400) begin
      bcnt++;
      wr_en = 1'b0; wr_kill = 1'b0;
      if (cyc == kill_at) begin wr_en = 1'b1; wr_kill = 1'b1; wr_data = 8'hA5; end
      if (cyc == poke_at) begin wr_en = 1'b1; wr_kill = 1'b0; wr_data = 8'd3; end
      @(negedge clk);
      cyc++;
    end
    wr_en = 1'b0; wr_kill = 1'b0;
    if (kill_at < 0) begin
      chk({req, " R5 busy cycles"}, bcnt, endv + 1);
      chk({req, " R5 done high"}, int'(done), 1);
    end else begin
      chk({req, " R8 busy cycles"}, bcnt, kill_at + 1);
      chk({req, " R8 no done"}, int'(done), 0);
    end
    @(negedge clk);
    chk({req, " R5 done one cycle"}, int'(done), 0);
    @(negedge clk);
    chk({req, " R6 addr held"}, int'(imem_addr),
        (kill_at < 0) ? endv : ((kill_at >= endv) ? endv : kill_at));
    chk({req, " R4 queue drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fetch_vld", int'(fetch_vld), 0);
    chk("R1 addr", int'(imem_addr), 0);

    run_prog(1, -1, -1, "end1");
    run_prog(5, -1, -1, "end5");
    run_prog(8'h5E, -1, -1, "R10 end94");
    run_prog(255, -1, -1, "end255");
    run_prog(10, 3, -1, "R8 kill mid");
    run_prog(6, 6, -1, "R8 kill at match");
    run_prog(7, 0, -1, "R8 kill first");
    run_prog(8, -1, 2, "R9 poke");

    // R7: zero write must not start
    wr_en = 1'b1; wr_kill = 1'b0; wr_data = '0;
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R7 zero write idle", int'(busy), 0);
      @(negedge clk);
    end
    // R8: kill while idle is harmless, next start still works
    wr_en = 1'b1; wr_kill = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_kill = 1'b0;
    chk("R8 idle kill busy", int'(busy), 0);
    run_prog(3, -1, -1, "after idle kill");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule